// File: doc/BRIEF.md
# Burst-of-two quad-data-rate SRAM model

A synthesizable behavioural model of a static RAM that has a dedicated read port and a dedicated write port. Each location is 36 bits wide and is always moved as two 18-bit beats, lower half first. The model runs in single-clock mode. Its clock input runs at twice the rate of the memory clock K, and an internal phase bit splits each K period into a high half, entered at a K rise, and a low half, entered at a K fall. A controller or testbench uses it in place of a real device when it needs cycle-exact read and write behaviour.

Both port selects are sampled only when K rises. A read takes its address at that edge. It returns the lower beat after the next rise and the upper beat after the fall that follows. A write takes its first beat at the rise. It takes its address and second beat at the following fall, and then holds the word in a short pipeline of `WR_LAT` K periods before it reaches the array. A read checks every write still in that pipeline and merges the newest one per 9-bit lane, so it always returns the latest data for its address. The array depth follows the address width parameter.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_ni` is low and straight after it rises, `rdata_oe_o` is 0, `rdata_o` is 0 and `k_high_o` is 0.
- R2: A read selected at a K rise (edge E of `clk_i`) drives the lower 18 bits of its location after edge E+2 and the upper 18 bits after edge E+3. `rdata_oe_o` is 1 for both beats.
- R3: `rdata_oe_o` returns to 0 at the K rise after an upper beat, unless a read started one K period after the first continues the stream with no gap.
- R4: A write takes beat 0 (word bits 17:0) at the K rise where it is selected, and takes its address and beat 1 (word bits 35:18) at the next K fall.
- R5: Write mask bit 0 (active low) enables bits 8:0 and bit 1 enables bits 17:9 of the beat sampled with it. A lane whose mask bit is high keeps its stored value.
- R6: A read and a write may both start at the same K rise, on different addresses, and neither disturbs the other.
- R7: A read returns every write selected at or before its own K rise, including a write at the same rise and at the previous rise. Lanes are merged with the newest write taking priority.
- R8: Port selects are ignored in the low half of K. A write whose select is released after its rise still completes its second beat.
- R9: The shared address bus is taken as a read address only at a K rise and as a write address only at a K fall.
- R10: `k_high_o` toggles on every `clk_i` edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Doubled-rate clock; alternate edges are K rise and K fall |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_ni | input | 1 | Read select, active low, sampled at K rise |
| wr_sel_ni | input | 1 | Write select, active low, sampled at K rise |
| addr_i | input | AW | Shared address bus |
| wdata_i | input | 18 | Write data beat |
| bsel_ni | input | 2 | Per-beat write lane masks, active low |
| rdata_o | output | 18 | Read data beat |
| rdata_oe_o | output | 1 | High while a read beat is driven |
| k_high_o | output | 1 | 1 during the high half of K |

## Verification
The bench builds the block with `AW=6` and `WR_LAT=3`. With 64 locations the bench can fill the whole array first, and random traffic over a handful of addresses collides often. A write pipeline of three K periods lets three writes to one address be in flight at once, which tests the newest-first lane merging that the default depth rarely reaches.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BEAT_W = 18;
  localparam int WORD_W = 2 * BEAT_W;
  localparam int LANE_W = 9;
  localparam int LANES  = WORD_W / LANE_W;

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0] en);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/qdr_phase.sv
module qdr_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic k_high_o,
  output logic k_rise_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;

  assign k_high_o = ph_q;
  assign k_rise_o = ~ph_q;  // next edge is a K rise
endmodule

// File: rtl/qdr_array.sv
module qdr_array import qdr_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wlane_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i)
      if (we_i && wlane_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/qdr_wr_pipe.sv
module qdr_wr_pipe import qdr_pkg::*; #(
  parameter int AW     = 8,
  parameter int WR_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              k_rise_i,
  input  logic              wr_sel_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [BEAT_W-1:0] wdata_i,
  input  logic [1:0]        bsel_ni,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [WORD_W-1:0] base_i,
  output logic [WORD_W-1:0] fwd_o,
  output logic              cm_en_o,
  output logic [AW-1:0]     cm_addr_o,
  output logic [WORD_W-1:0] cm_data_o,
  output logic [LANES-1:0]  cm_lane_o
);
  localparam int LAST = WR_LAT - 1;

  logic              act_q;
  logic [BEAT_W-1:0] b0_q;
  logic [1:0]        m0_q;
  logic              v_q [WR_LAT];
  logic [AW-1:0]     a_q [WR_LAT];
  logic [WORD_W-1:0] d_q [WR_LAT];
  logic [LANES-1:0]  m_q [WR_LAT];

  // control: select taken at rise only; pipeline advances at each fall
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_q <= 1'b0;
      for (int s = 0; s < WR_LAT; s++) v_q[s] <= 1'b0;
    end else if (k_rise_i) begin
      act_q <= ~wr_sel_ni;
    end else begin
      act_q  <= 1'b0;
      v_q[0] <= act_q;
      for (int s = LAST; s > 0; s--) v_q[s] <= v_q[s-1];
    end

  always_ff @(posedge clk_i)
    if (k_rise_i) begin
      if (!wr_sel_ni) begin
        b0_q <= wdata_i;
        m0_q <= ~bsel_ni;
      end
    end else begin
      a_q[0] <= addr_i;
      d_q[0] <= {wdata_i, b0_q};
      m_q[0] <= {~bsel_ni, m0_q};
      for (int s = LAST; s > 0; s--) begin
        a_q[s] <= a_q[s-1];
        d_q[s] <= d_q[s-1];
        m_q[s] <= m_q[s-1];
      end
    end

  assign cm_en_o   = ~k_rise_i & v_q[LAST];
  assign cm_addr_o = a_q[LAST];
  assign cm_data_o = d_q[LAST];
  assign cm_lane_o = m_q[LAST];

  // oldest first so the newest pending write wins per lane
  always_comb begin
    fwd_o = base_i;
    for (int s = LAST; s >= 0; s--)
      if (v_q[s] && a_q[s] == rd_addr_i) fwd_o = lane_merge(fwd_o, d_q[s], m_q[s]);
  end
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port import qdr_pkg::*; #(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              k_rise_i,
  input  logic              rd_sel_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic [BEAT_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              pend_q;
  logic              up_due_q;
  logic [AW-1:0]     ra_q;
  logic [BEAT_W-1:0] up_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      up_due_q   <= 1'b0;
      ra_q       <= '0;
      up_q       <= '0;
      rdata_o    <= '0;
      rdata_oe_o <= 1'b0;
    end else if (k_rise_i) begin
      pend_q <= ~rd_sel_ni;
      if (!rd_sel_ni) ra_q <= addr_i;
      if (pend_q) begin
        rdata_o    <= word_i[BEAT_W-1:0];
        up_q       <= word_i[WORD_W-1:BEAT_W];
        rdata_oe_o <= 1'b1;
        up_due_q   <= 1'b1;
      end else begin
        rdata_o    <= '0;
        rdata_oe_o <= 1'b0;
        up_due_q   <= 1'b0;
      end
    end else begin
      if (up_due_q) rdata_o <= up_q;
      up_due_q <= 1'b0;
    end

  assign rd_addr_o = ra_q;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram import qdr_pkg::*; #(
  parameter int AW     = 8,
  parameter int WR_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [BEAT_W-1:0] wdata_i,
  input  logic [1:0]        bsel_ni,
  output logic [BEAT_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              k_high_o
);
  logic              k_rise;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] arr_word, fwd_word, cm_data;
  logic [AW-1:0]     cm_addr;
  logic [LANES-1:0]  cm_lane;
  logic              cm_en;

  qdr_phase u_ph (
    .clk_i(clk_i), .rst_ni(rst_ni), .k_high_o(k_high_o), .k_rise_o(k_rise)
  );

  qdr_wr_pipe #(.AW(AW), .WR_LAT(WR_LAT)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .k_rise_i(k_rise),
    .wr_sel_ni(wr_sel_ni), .addr_i(addr_i), .wdata_i(wdata_i), .bsel_ni(bsel_ni),
    .rd_addr_i(rd_addr), .base_i(arr_word), .fwd_o(fwd_word),
    .cm_en_o(cm_en), .cm_addr_o(cm_addr), .cm_data_o(cm_data), .cm_lane_o(cm_lane)
  );

  qdr_array #(.AW(AW)) u_arr (
    .clk_i(clk_i), .we_i(cm_en), .waddr_i(cm_addr), .wdata_i(cm_data),
    .wlane_i(cm_lane), .raddr_i(rd_addr), .rdata_o(arr_word)
  );

  qdr_rd_port #(.AW(AW)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .k_rise_i(k_rise),
    .rd_sel_ni(rd_sel_ni), .addr_i(addr_i), .word_i(fwd_word),
    .rd_addr_o(rd_addr), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
  );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_sel_ni,
  input logic rdata_oe_o,
  input logic k_high_o
);
  // R10
  ph_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_high_o |=> k_high_o);
  // R10
  ph_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_high_o |=> !k_high_o);
  // R2
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!k_high_o && !rd_sel_ni) |-> ##3 rdata_oe_o);
  // R2
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_oe_o) |-> k_high_o);
  // R3
  upper_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && k_high_o) |=> rdata_oe_o);
  // R3
  oe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_oe_o) |-> k_high_o);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_sel_ni(rd_sel_ni),
  .rdata_oe_o(rdata_oe_o), .k_high_o(k_high_o)
);

// File: tb/sim_qdr_b2_sram.sv
`timescale 1ns/1ps
module sim_qdr_b2_sram;
  localparam int BAW = 6;
  localparam int BLAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [BAW-1:0] addr = '0;
  logic [17:0] wdata = '0;
  logic [1:0] bsel_n = 2'b11;
  logic [17:0] rdata;
  logic oe, k_high;

  int checks = 0, failures = 0, ec = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) ec <= ec + 1;

  qdr_b2_sram #(.AW(BAW), .WR_LAT(BLAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_sel_ni(rd_sel_n), .wr_sel_ni(wr_sel_n),
    .addr_i(addr), .wdata_i(wdata), .bsel_ni(bsel_n),
    .rdata_o(rdata), .rdata_oe_o(oe), .k_high_o(k_high)
  );

  logic [35:0] ref_mem [1 << BAW];

  typedef struct { int due; logic [17:0] d; string tag; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one K period: rise half then fall half
  task automatic kcyc(input bit rd, input logic [BAW-1:0] ra, input bit wr, input logic [BAW-1:0] wa,
                      input logic [17:0] d0, input logic [17:0] d1,
                      input logic [1:0] m0, input logic [1:0] m1,
                      input string tag, input bit glitch);
    logic [35:0] w, nw;
    do @(negedge clk); while (k_high);
    rd_sel_n = !rd;
    wr_sel_n = !wr;
    addr   = rd ? ra : ~wa;           // R9: non-read rise address is junk
    wdata  = d0;
    bsel_n = m0;
    if (wr) begin
      w  = ref_mem[wa];
      nw = {d1, d0};
      if (!m0[0]) w[8:0]   = nw[8:0];
      if (!m0[1]) w[17:9]  = nw[17:9];
      if (!m1[0]) w[26:18] = nw[26:18];
      if (!m1[1]) w[35:27] = nw[35:27];
      ref_mem[wa] = w;
    end
    if (rd) begin
      q.push_back('{ec + 3, ref_mem[ra][17:0], tag});
      q.push_back('{ec + 4, ref_mem[ra][35:18], tag});
    end
    @(negedge clk);
    rd_sel_n = glitch ? 1'b0 : 1'b1;  // R8: fall-half selects ignored
    wr_sel_n = glitch ? 1'b0 : 1'b1;
    addr   = wr ? wa : ~ra;           // R9: non-write fall address is junk
    wdata  = d1;
    bsel_n = m1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(0, '0, 0, '0, 18'h3ffff, 18'h3ffff, 2'b00, 2'b00, "idle", 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    bit exp_oe;
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].due < ec) begin
        chk(0, {q[0].tag, " missing beat"}, '0, {18'h0, q[0].d});
        void'(q.pop_front());
      end
      exp_oe = q.size() > 0 && q[0].due == ec;
      if (exp_oe || oe) begin
        if (!exp_oe) chk(0, "R3 stray oe", {17'h0, oe, rdata}, '0);
        else chk(oe && rdata == q[0].d, q[0].tag, {17'h0, oe, rdata}, {18'h1, q[0].d});
        if (exp_oe) void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(oe == 0 && rdata == 0 && k_high == 0, "R1 in reset", {oe, k_high, rdata}, '0);
    rst_n = 1'b1;
    @(negedge clk); chk(k_high == 1, "R10 phase", {35'h0, k_high}, 36'h1);
    @(negedge clk); chk(k_high == 0, "R10 phase", {35'h0, k_high}, 36'h0);
    chk(oe == 0 && rdata == 0, "R1 after reset", {oe, rdata}, '0);

    // R4: fill every location, back to back
    for (int a = 0; a < (1 << BAW); a++)
      kcyc(0, '0, 1, a[BAW-1:0], 18'h01000 + 18'(a), 18'h2a000 + 18'(a), 2'b00, 2'b00, "R4", 0);
    idle(BLAT + 1);
    // R2 isolated reads, R3 streaming reads
    kcyc(1, 6'd5, 0, '0, 0, 0, 2'b11, 2'b11, "R2 isolated", 0);
    idle(2);
    for (int a = 10; a < 16; a++) kcyc(1, a[BAW-1:0], 0, '0, 0, 0, 2'b11, 2'b11, "R3 stream", 0);
    idle(2);
    kcyc(1, 6'd20, 0, '0, 0, 0, 2'b11, 2'b11, "R3 gap", 0);
    idle(1);
    kcyc(1, 6'd21, 0, '0, 0, 0, 2'b11, 2'b11, "R3 gap", 0);
    idle(2);
    // R5 lane masks in every combination
    for (int m = 0; m < 16; m++) begin
      kcyc(0, '0, 1, 6'd30, 18'h15555 ^ 18'(m), 18'h0aaaa ^ 18'(m << 4),
           m[1:0], m[3:2], "R5", 0);
      idle(BLAT + 1);
      kcyc(1, 6'd30, 0, '0, 0, 0, 2'b11, 2'b11, "R5 lane mask", 0);
    end
    idle(2);
    // R6 same rise, different addresses
    kcyc(1, 6'd40, 1, 6'd41, 18'h11111, 18'h22222, 2'b00, 2'b00, "R6 concurrent", 0);
    kcyc(1, 6'd41, 0, '0, 0, 0, 2'b11, 2'b11, "R6 after", 0);
    idle(2);
    // R7 same-rise and previous-rise forwarding
    kcyc(1, 6'd42, 1, 6'd42, 18'h33333, 18'h04444, 2'b10, 2'b01, "R7 same rise", 0);
    kcyc(0, '0, 1, 6'd43, 18'h05555, 18'h06666, 2'b00, 2'b00, "R7", 0);
    kcyc(1, 6'd43, 0, '0, 0, 0, 2'b11, 2'b11, "R7 prev rise", 0);
    // R7 newest-first with several writes in flight
    kcyc(0, '0, 1, 6'd44, 18'h0aaaa, 18'h0bbbb, 2'b00, 2'b00, "R7", 0);
    kcyc(0, '0, 1, 6'd44, 18'h0cccc, 18'h0dddd, 2'b01, 2'b10, "R7", 0);
    kcyc(1, 6'd44, 1, 6'd44, 18'h0eeee, 18'h0ffff, 2'b10, 2'b11, "R7 newest wins", 0);
    idle(BLAT + 2);
    // R8 fall-half selects only; R9 junk addresses were driven throughout
    kcyc(1, 6'd60, 0, '0, 0, 0, 2'b11, 2'b11, "R8 glitch read", 1);
    kcyc(1, 6'd61, 0, '0, 0, 0, 2'b11, 2'b11, "R9 untouched", 0);
    kcyc(1, 6'd62, 0, '0, 0, 0, 2'b11, 2'b11, "R9 untouched", 0);
    idle(2);
    // mixed random traffic on a small address window
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      kcyc(r[0], {3'b0, r[3:1]}, r[4], {3'b0, r[7:5]}, 18'($urandom), 18'($urandom),
           r[9:8], r[11:10], "R7 random", r[12]);
    end
    idle(BLAT + 3);
    chk(q.size() == 0, "R2 drained", 36'(q.size()), '0);
    chk(oe == 0, "R3 idle", {35'h0, oe}, '0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule